// File: doc/BRIEF.md
# Chained Two-Stage Timer

A pair of 16-bit up-counters that together make one 32-bit free-running count. The low stage counts the system clock through its own prescaler. When it rolls over from 0xFFFF to 0x0000 it raises a one-cycle update event. A master-mode field chooses what the low stage exports on its trigger output. The high stage does not take a carry wire. It takes a trigger selected from a small set of internal sources, and a slave-mode field turns rising edges on that trigger into count ticks. The high stage can instead count the clock directly, or hold.

Software configures the pair through a single write port. It sets both prescalers to zero, sets the low stage's master mode to "update", points the high stage's trigger select at the low stage and picks the edge-clocked slave mode. It enables the high stage first and the low stage last. The two counters can be read at any time on their own output ports. Two auxiliary trigger inputs give the high stage other event sources.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, lo_count and hi_count are 0x0000 and trg_out is low.
- R2: A write (cfg_we high) takes effect at the clock edge that samples it. cfg_addr 0 is the low prescaler. Address 1 is the low control: bit 0 enable, bits 3:1 master mode. Address 2 is the high prescaler. Address 3 is the high control: bit 0 enable, bits 3:1 trigger select, bits 6:4 slave mode. Address 4 loads the low count and address 5 loads the high count. Writes to addresses 6 and 7 change nothing.
- R3: With prescaler P, the enabled low counter advances by one once every P+1 clocks (every clock when P is 0) and wraps from 0xFFFF to 0x0000.
- R4: With master mode 3'b010, trg_out is high for exactly the one cycle in which lo_count first shows 0x0000 after a rollover.
- R5: Any master mode other than 3'b010 keeps trg_out low.
- R6: With slave mode 3'b111, each rising edge of the selected trigger adds one to the high counter at the following clock edge. With trigger select 3'b001, hi_count therefore steps in the cycle after lo_count first reads 0x0000.
- R7: Trigger select 3'b001 picks the low stage's trigger output, 3'b010 picks aux_trig[0] and 3'b011 picks aux_trig[1]. Codes 3'b000 and 3'b100 to 3'b111 pick a constant low.
- R8: Slave mode 3'b000 makes the enabled high counter count the clock like the low one. Slave modes 3'b001 to 3'b110 hold it.
- R9: The high prescaler Q divides the high stage's ticks, so it advances once every Q+1 ticks.
- R10: A cleared enable freezes its own counter. Freezing the low stage therefore freezes the whole chained value. Rollovers that happen while the high stage is disabled are never counted later.
- R11: A count load is visible the next cycle, overrides a same-cycle increment and restarts the prescaler phase, so the next increment comes after exactly P+1 enabled clocks.
- R12: In chained configuration, after N enabled low-stage clocks the 32-bit value {hi_count, lo_count} equals its start value plus floor(N/(P+1)), modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| aux_trig | input | 2 | Auxiliary trigger sources for the high stage |
| lo_count | output | 16 | Low-stage counter value |
| hi_count | output | 16 | High-stage counter value |
| trg_out | output | 1 | Low-stage trigger output |

## Verification
Directed runs start the low word just below 0xFFFF and sample every cycle around the wrap. This separates a correctly placed one-cycle trigger and one-clock high-word step from an early, late or stretched carry. The same wrap is repeated under every unsupported master mode, every unused trigger select and every holding slave mode. That tells whether the high word is fed only by the intended fabric path. Auxiliary-trigger pulse trains with different high prescalers set apart edge counting from level counting and show the division. Random runs with random start points, prescalers and lengths, plus one long run across two rollovers, compare the full 32-bit value with the arithmetic expectation.

// File: rtl/ctp_pkg.sv
`timescale 1ns/1ps
package ctp_pkg;
  localparam int MODE_W = 3;

  localparam logic [2:0] A_LO_PSC = 3'd0;
  localparam logic [2:0] A_LO_CTL = 3'd1;
  localparam logic [2:0] A_HI_PSC = 3'd2;
  localparam logic [2:0] A_HI_CTL = 3'd3;
  localparam logic [2:0] A_LO_CNT = 3'd4;
  localparam logic [2:0] A_HI_CNT = 3'd5;

  typedef enum logic [MODE_W-1:0] {
    MM_RESET  = 3'b000,
    MM_ENABLE = 3'b001,
    MM_UPDATE = 3'b010
  } master_mode_e;

  typedef enum logic [MODE_W-1:0] {
    SM_INTERNAL = 3'b000,
    SM_EDGE_CLK = 3'b111
  } slave_mode_e;

  localparam int TS_LO_TRIG = 1;
  localparam int TS_AUX_BASE = 2;
endpackage

// File: rtl/ctp_timer_core.sv
`timescale 1ns/1ps
module ctp_timer_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] psc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         upd
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] pcnt_q, pcnt_d;
  logic         upd_q, upd_d;
  logic         fire;

  // Next state: load has priority over counting and suppresses the update.
  always_comb begin
    fire   = tick && (pcnt_q >= psc);
    cnt_d  = cnt_q;
    pcnt_d = pcnt_q;
    if (ld) begin
      cnt_d  = ld_val;
      pcnt_d = '0;
    end else if (tick) begin
      if (fire) begin
        cnt_d  = cnt_q + ONE;
        pcnt_d = '0;
      end else begin
        pcnt_d = pcnt_q + ONE;
      end
    end
    upd_d = fire && !ld && (cnt_q == TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pcnt_q <= pcnt_d;
      upd_q  <= upd_d;
    end
  end

  assign cnt = cnt_q;
  assign upd = upd_q;
endmodule

// File: rtl/ctp_master_sel.sv
`timescale 1ns/1ps
module ctp_master_sel
  import ctp_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              upd,
  output logic              trgo
);
  always_comb begin
    if (mode == MM_UPDATE) trgo = upd;
    else                   trgo = 1'b0;
  end
endmodule

// File: rtl/ctp_slave_ctrl.sv
`timescale 1ns/1ps
module ctp_slave_ctrl
  import ctp_pkg::*;
#(
  parameter int TS_W = 3,
  localparam int NSRC = 1 << TS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [TS_W-1:0]   tsel,
  input  logic [MODE_W-1:0] smode,
  input  logic [NSRC-1:0]   src,
  output logic              tick
);
  logic sel;
  logic trig_q, trig_d;
  logic rise;

  // Edge history follows the selected source even while disabled.
  always_comb begin
    sel    = src[tsel];
    trig_d = sel;
    rise   = sel && !trig_q;
    case (smode)
      SM_INTERNAL: tick = en;
      SM_EDGE_CLK: tick = en && rise;
      default:     tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end
endmodule

// File: rtl/cascade_timer_pair.sv
`timescale 1ns/1ps
module cascade_timer_pair
  import ctp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AUX_N = 2,
  parameter int TS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic [AUX_N-1:0] aux_trig,
  output logic [CNT_W-1:0] lo_count,
  output logic [CNT_W-1:0] hi_count,
  output logic             trg_out
);
  localparam int NSRC = 1 << TS_W;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // Configuration registers.
  logic [CNT_W-1:0]  lo_psc_q, lo_psc_d, hi_psc_q, hi_psc_d;
  logic              lo_en, lo_en_d, hi_en, hi_en_d;
  logic [MODE_W-1:0] lo_mm, lo_mm_d, hi_sms_q, hi_sms_d;
  logic [TS_W-1:0]   hi_ts_q, hi_ts_d;
  logic              lo_ld, hi_ld;

  always_comb begin
    lo_psc_d = lo_psc_q;
    hi_psc_d = hi_psc_q;
    lo_en_d  = lo_en;
    lo_mm_d  = lo_mm;
    hi_en_d  = hi_en;
    hi_ts_d  = hi_ts_q;
    hi_sms_d = hi_sms_q;
    lo_ld    = 1'b0;
    hi_ld    = 1'b0;
    if (cfg_we) begin
      case (cfg_addr)
        A_LO_PSC: lo_psc_d = cfg_wdata;
        A_LO_CTL: begin
          lo_en_d = cfg_wdata[0];
          lo_mm_d = cfg_wdata[3:1];
        end
        A_HI_PSC: hi_psc_d = cfg_wdata;
        A_HI_CTL: begin
          hi_en_d  = cfg_wdata[0];
          hi_ts_d  = cfg_wdata[TS_W:1];
          hi_sms_d = cfg_wdata[6:4];
        end
        A_LO_CNT: lo_ld = 1'b1;
        A_HI_CNT: hi_ld = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      lo_psc_q <= '0;
      hi_psc_q <= '0;
      lo_en    <= 1'b0;
      lo_mm    <= '0;
      hi_en    <= 1'b0;
      hi_ts_q  <= '0;
      hi_sms_q <= '0;
    end else begin
      lo_psc_q <= lo_psc_d;
      hi_psc_q <= hi_psc_d;
      lo_en    <= lo_en_d;
      lo_mm    <= lo_mm_d;
      hi_en    <= hi_en_d;
      hi_ts_q  <= hi_ts_d;
      hi_sms_q <= hi_sms_d;
    end
  end

  // Low stage.
  logic lo_upd, lo_trgo;

  ctp_timer_core #(.W(CNT_W)) u_lo (
    .clk(clk), .rst_n(rst_s), .tick(lo_en), .psc(lo_psc_q),
    .ld(lo_ld), .ld_val(cfg_wdata), .cnt(lo_count), .upd(lo_upd)
  );

  ctp_master_sel u_msel (.mode(lo_mm), .upd(lo_upd), .trgo(lo_trgo));

  // Trigger fabric: one slot per select code.
  logic [NSRC-1:0] trig_src;
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == TS_LO_TRIG) begin : g_lo
      assign trig_src[i] = lo_trgo;
    end else if (i >= TS_AUX_BASE && i < TS_AUX_BASE + AUX_N) begin : g_aux
      assign trig_src[i] = aux_trig[i - TS_AUX_BASE];
    end else begin : g_zero
      assign trig_src[i] = 1'b0;
    end
  end

  // High stage.
  logic hi_tick, hi_upd;

  ctp_slave_ctrl #(.TS_W(TS_W)) u_slave (
    .clk(clk), .rst_n(rst_s), .en(hi_en), .tsel(hi_ts_q),
    .smode(hi_sms_q), .src(trig_src), .tick(hi_tick)
  );

  ctp_timer_core #(.W(CNT_W)) u_hi (
    .clk(clk), .rst_n(rst_s), .tick(hi_tick), .psc(hi_psc_q),
    .ld(hi_ld), .ld_val(cfg_wdata), .cnt(hi_count), .upd(hi_upd)
  );

  assign trg_out = lo_trgo;
endmodule

// File: rtl/ctp_checker.sv
`timescale 1ns/1ps
module ctp_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_s,
  input logic         trg_out,
  input logic [W-1:0] lo_count,
  input logic [W-1:0] hi_count,
  input logic [2:0]   lo_mm,
  input logic         lo_en,
  input logic         lo_ld,
  input logic         hi_en,
  input logic         hi_ld
);
  // R4: the trigger pulse lasts one cycle.
  p_trg_single_r4: assert property (@(posedge clk) disable iff (!rst_s)
    trg_out |=> !trg_out);

  // R4: the trigger only appears while the low word reads zero.
  p_trg_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_s)
    trg_out |-> (lo_count == '0));

  // R5: unsupported master modes keep the trigger low.
  p_mm_quiet_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (lo_mm != 3'b010) |-> !trg_out);

  // R6: without a load the high word moves by at most one per clock.
  p_hi_step_r6: assert property (@(posedge clk) disable iff (!rst_s)
    !hi_ld |=> ((hi_count == $past(hi_count)) ||
                (hi_count == W'($past(hi_count) + 1'b1))));

  // R10: a disabled low stage holds its count.
  p_lo_freeze_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (!lo_en && !lo_ld) |=> $stable(lo_count));

  // R10: a disabled high stage holds its count.
  p_hi_freeze_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (!hi_en && !hi_ld) |=> $stable(hi_count));
endmodule

bind cascade_timer_pair ctp_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .trg_out(trg_out), .lo_count(lo_count),
  .hi_count(hi_count), .lo_mm(lo_mm), .lo_en(lo_en), .lo_ld(lo_ld),
  .hi_en(hi_en), .hi_ld(hi_ld)
);

// File: tb/cascade_timer_pair_test.sv
`timescale 1ns/1ps
module cascade_timer_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  aux_trig = '0;
  logic [15:0] lo_count, hi_count;
  logic        trg_out;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_timer_pair uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .aux_trig(aux_trig), .lo_count(lo_count),
    .hi_count(hi_count), .trg_out(trg_out)
  );

  function automatic logic [15:0] lo_ctl(input logic en, input logic [2:0] mm);
    return {12'd0, mm, en};
  endfunction

  function automatic logic [15:0] hi_ctl(input logic en, input logic [2:0] ts,
                                         input logic [2:0] sm);
    return {9'd0, sm, ts, en};
  endfunction

  // Expected 32-bit value after n enabled clocks with prescaler p.
  function automatic logic [31:0] chain_exp(input logic [31:0] start,
                                            input int unsigned n,
                                            input int unsigned p);
    return start + 32'(n / (p + 1));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      aux_trig[idx] = 1'b1;
      @(negedge clk);
      aux_trig[idx] = 1'b0;
      @(negedge clk);
    end
  endtask

  // Short low-stage run from 0xFFFF so that one rollover happens.
  task automatic wrap_once(input logic [2:0] mm, output int trg_seen);
    trg_seen = 0;
    wr(3'd4, 16'hFFFF);
    wr(3'd1, lo_ctl(1'b1, mm));
    for (int k = 0; k < 3; k++) begin
      if (trg_out) trg_seen++;
      @(negedge clk);
    end
    wr(3'd1, lo_ctl(1'b0, mm));
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seen;
    logic [15:0] h0;
    int unsigned seed;
    seed = 32'h5EED;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    chk("R1 lo_count", 32'(lo_count), 32'h0);
    chk("R1 hi_count", 32'(hi_count), 32'h0);
    chk("R1 trg_out", 32'(trg_out), 32'h0);

    // Chained configuration, high stage enabled first.
    wr(3'd0, 16'd0);
    wr(3'd2, 16'd0);
    wr(3'd3, hi_ctl(1'b1, 3'd1, 3'd7));
    wr(3'd1, lo_ctl(1'b0, 3'd2));

    // R3 / R4 / R6: cycle-by-cycle across a rollover.
    wr(3'd4, 16'hFFFE);
    wr(3'd5, 16'd5);
    wr(3'd1, lo_ctl(1'b1, 3'd2));
    chk("R3 start", 32'(lo_count), 32'hFFFE);
    @(negedge clk);
    chk("R3 step", 32'(lo_count), 32'hFFFF);
    chk("R4 no early trigger", 32'(trg_out), 32'h0);
    @(negedge clk);
    chk("R3 wrap", 32'(lo_count), 32'h0);
    chk("R4 trigger on zero", 32'(trg_out), 32'h1);
    chk("R6 high not yet", 32'(hi_count), 32'd5);
    @(negedge clk);
    chk("R4 trigger one cycle", 32'(trg_out), 32'h0);
    chk("R6 high stepped", 32'(hi_count), 32'd6);
    wr(3'd1, lo_ctl(1'b0, 3'd2));
    chk("R10 last count", 32'(lo_count), 32'd2);
    @(negedge clk);
    chk("R10 low frozen", {hi_count, lo_count}, {16'd6, 16'd2});

    // R2: writes to unused addresses change nothing.
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    repeat (3) @(negedge clk);
    chk("R2 unused address", {hi_count, lo_count}, {16'd6, 16'd2});

    // R5: unsupported master modes.
    seen = 0;
    for (int m = 0; m < 8; m++) begin
      int s;
      if (m == 2) continue;
      wrap_once(3'(m), s);
      seen += s;
    end
    chk("R5 trigger stays low", 32'(seen), 32'h0);
    chk("R5 high unchanged", 32'(hi_count), 32'd6);

    // R7: auxiliary sources.
    wr(3'd5, 16'd100);
    wr(3'd3, hi_ctl(1'b1, 3'd2, 3'd7));
    pulse(0, 5);
    pulse(1, 3);
    @(negedge clk);
    chk("R7 select aux0", 32'(hi_count), 32'd105);
    wrap_once(3'd2, seen);
    chk("R7 aux0 ignores low wrap", 32'(hi_count), 32'd105);
    wr(3'd3, hi_ctl(1'b1, 3'd3, 3'd7));
    pulse(1, 3);
    pulse(0, 4);
    @(negedge clk);
    chk("R7 select aux1", 32'(hi_count), 32'd108);
    for (int t = 0; t < 8; t++) begin
      if (t >= 1 && t <= 3) continue;
      wr(3'd3, hi_ctl(1'b1, 3'(t), 3'd7));
      pulse(0, 2);
      pulse(1, 2);
      wrap_once(3'd2, seen);
    end
    chk("R7 constant-low selects", 32'(hi_count), 32'd108);

    // R8: internal counting and holding modes.
    wr(3'd5, 16'd0);
    wr(3'd3, hi_ctl(1'b1, 3'd0, 3'd0));
    repeat (9) @(negedge clk);
    wr(3'd3, hi_ctl(1'b0, 3'd0, 3'd0));
    chk("R8 internal clock", 32'(hi_count), 32'd10);
    for (int s = 1; s < 7; s++) begin
      wr(3'd3, hi_ctl(1'b1, 3'd1, 3'(s)));
      repeat (4) @(negedge clk);
      wrap_once(3'd2, seen);
    end
    wr(3'd3, hi_ctl(1'b0, 3'd1, 3'd7));
    chk("R8 hold modes", 32'(hi_count), 32'd10);

    // R9: high prescaler on edges and on internal clock.
    wr(3'd2, 16'd2);
    wr(3'd5, 16'd0);
    wr(3'd3, hi_ctl(1'b1, 3'd2, 3'd7));
    pulse(0, 7);
    @(negedge clk);
    chk("R9 divide edges by 3", 32'(hi_count), 32'd2);
    wr(3'd2, 16'd1);
    wr(3'd5, 16'd0);
    wr(3'd3, hi_ctl(1'b1, 3'd0, 3'd0));
    repeat (7) @(negedge clk);
    wr(3'd3, hi_ctl(1'b0, 3'd0, 3'd0));
    chk("R9 divide clock by 2", 32'(hi_count), 32'd4);
    wr(3'd2, 16'd0);

    // R10: rollover while the high stage is disabled is lost.
    wr(3'd5, 16'd40);
    wr(3'd3, hi_ctl(1'b0, 3'd1, 3'd7));
    wrap_once(3'd2, seen);
    chk("R10 trigger did fire", 32'(seen), 32'd1);
    wr(3'd3, hi_ctl(1'b1, 3'd1, 3'd7));
    repeat (3) @(negedge clk);
    chk("R10 missed rollover", 32'(hi_count), 32'd40);

    // R11: loads override counting and restart the prescaler phase.
    wr(3'd4, 16'd10);
    wr(3'd1, lo_ctl(1'b1, 3'd2));
    repeat (5) @(negedge clk);
    wr(3'd4, 16'd1234);
    chk("R11 load wins", 32'(lo_count), 32'd1234);
    @(negedge clk);
    chk("R11 resumes", 32'(lo_count), 32'd1235);
    wr(3'd0, 16'd2);
    wr(3'd4, 16'd500);
    chk("R11 load value", 32'(lo_count), 32'd500);
    @(negedge clk);
    chk("R11 phase 1", 32'(lo_count), 32'd500);
    @(negedge clk);
    chk("R11 phase 2", 32'(lo_count), 32'd500);
    @(negedge clk);
    chk("R11 phase 3", 32'(lo_count), 32'd501);
    wr(3'd1, lo_ctl(1'b0, 3'd2));
    wr(3'd0, 16'd0);

    // R12: long run over two rollovers, then random runs.
    wr(3'd4, 16'hFFF0);
    wr(3'd5, 16'd7);
    wr(3'd1, lo_ctl(1'b1, 3'd2));
    repeat (65600) @(negedge clk);
    wr(3'd1, lo_ctl(1'b0, 3'd2));
    repeat (3) @(negedge clk);
    chk("R12 long run", {hi_count, lo_count}, chain_exp({16'd7, 16'hFFF0}, 65601, 0));

    for (int t = 0; t < 10; t++) begin
      int unsigned p, m;
      logic [15:0] l0;
      p  = $urandom % 4;
      m  = ($urandom % 4000) + 50;
      l0 = 16'hFFFF - 16'($urandom % 3000);
      h0 = 16'($urandom);
      wr(3'd0, 16'(p));
      wr(3'd4, l0);
      wr(3'd5, h0);
      wr(3'd1, lo_ctl(1'b1, 3'd2));
      repeat (m) @(negedge clk);
      wr(3'd1, lo_ctl(1'b0, 3'd2));
      repeat (3) @(negedge clk);
      chk("R12 random run", {hi_count, lo_count}, chain_exp({h0, l0}, m + 1, p));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule